// File: doc/BRIEF.md
# Multi-Channel Pulse Counter Bank

This block counts pulses on five independent single-ended lines, for use as frequency counters or single-channel speed inputs. It also samples a bank of ten discrete digital inputs. Every line passes through a deglitching filter before it is used. The filter changes its output only after the raw line has held a new level for three clocks in a row. Each counter channel adds one on every rising edge of its filtered line. The counters run freely and wrap at the top of their range.

An external loop strobe copies all five counters into holding registers on a single clock edge, so one read pass returns a coherent set of values. Software takes the difference between two successive snapshots to get the pulse count for one loop period. A small combinational read port returns one holding register or the filtered discrete word, selected by address.

Top module: `pulse_count_bank`

## Requirements
- R1: After reset, every address of the read port returns zero.
- R2: A filtered line changes level on the third consecutive rising clock edge at which the raw line shows the new level. A raw excursion that lasts only one or two clocks leaves the filtered line unchanged.
- R3: A counter adds exactly one for each rising edge of its filtered line. Falling edges, and pulses that the filter rejects, leave it unchanged.
- R4: A counter wraps from its all-ones value to zero on the next counted edge.
- R5: A clock edge at which the load strobe is high copies all five counters into their holding registers together. At any other edge the holding registers keep their contents.
- R6: Read addresses 0 to 4 return the holding register of channels 0 to 4.
- R7: Read address 5 returns the filtered discrete word in bits 9:0, with the remaining upper bits zero. Addresses 6 and 7 return zero.
- R8: The discrete inputs use the same three-clock filter as the counter inputs and are readable without a load strobe.
- R9: Channels count independently: pulses on one line never change another channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_in_i | input | 5 | Raw counter input lines, one per channel |
| din_i | input | 10 | Raw discrete input lines |
| load_i | input | 1 | Loop strobe that snapshots all counters |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data, combinational from the address |

## Verification
The bench measures the filter's timing to the exact clock for both directions on a discrete bit. It then sends two-clock glitches, which a filter that reacts too early would pass. It mixes multi-channel pulse masks with rejected glitches, so a design that counts falling edges, leaks between channels or counts short pulses reads back wrong totals. It keeps counting between strobes to catch holding registers that track the live counter. A narrow copy of the block is driven past its all-ones value to show that the count wraps rather than saturating, and the upper bits of the discrete word are checked to be zero.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned PCB_N_CH  = 5;
  localparam int unsigned PCB_N_DIN = 10;
  localparam int unsigned PCB_CNT_W = 16;
  localparam int unsigned PCB_ADR_W = 3;
endpackage

// File: rtl/pcb_filter3.sv
module pcb_filter3 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] filt_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] hist0, hist1, q;
  logic [W-1:0] all_hi, all_lo;

  assign all_hi = raw_i & hist0 & hist1;
  assign all_lo = ~raw_i & ~hist0 & ~hist1;
  assign rise_o = all_hi & ~q;
  assign filt_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist0 <= '0;
      hist1 <= '0;
      q     <= '0;
    end else begin
      hist0 <= raw_i;
      hist1 <= hist0;
      q     <= (q | all_hi) & ~all_lo;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R2: any output change follows three agreeing raw samples
    a_r2_three_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q[i] != $past(q[i])) |->
        ($past(raw_i[i], 1) == q[i] && $past(raw_i[i], 2) == q[i] && $past(raw_i[i], 3) == q[i]));
  end
endmodule

// File: rtl/pcb_edge_counter.sv
module pcb_edge_counter #(
  parameter int unsigned N     = 5,
  parameter int unsigned CNT_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0]             inc_i,
  output logic [N-1:0][CNT_W-1:0]  cnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o[i] <= '0;
      else if (inc_i[i]) cnt_o[i] <= cnt_o[i] + 1'b1;
    end

    a_r3_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(inc_i[i]) |-> cnt_o[i] == CNT_W'($past(cnt_o[i]) + 1'b1));
    a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(inc_i[i]) |-> $stable(cnt_o[i]));
  end
endmodule

// File: rtl/pulse_count_bank.sv
module pulse_count_bank
  import pcb_pkg::*;
#(
  parameter int unsigned N_CH   = PCB_N_CH,
  parameter int unsigned N_DIN  = PCB_N_DIN,
  parameter int unsigned CNT_W  = PCB_CNT_W,
  parameter int unsigned ADR_W  = PCB_ADR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  cnt_in_i,
  input  logic [N_DIN-1:0] din_i,
  input  logic             load_i,
  input  logic [ADR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int unsigned DIN_ADDR = N_CH;

  logic [N_CH-1:0]            ch_filt, ch_rise;
  logic [N_DIN-1:0]           din_filt, din_rise;
  logic [N_CH-1:0][CNT_W-1:0] cnt, hold;

  pcb_filter3 #(.W(N_CH)) u_ch_filt (
    .clk_i, .rst_ni, .raw_i(cnt_in_i), .filt_o(ch_filt), .rise_o(ch_rise)
  );

  pcb_filter3 #(.W(N_DIN)) u_din_filt (
    .clk_i, .rst_ni, .raw_i(din_i), .filt_o(din_filt), .rise_o(din_rise)
  );

  pcb_edge_counter #(.N(N_CH), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(ch_rise), .cnt_o(cnt)
  );

  // one enable for the whole bank keeps the snapshot coherent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold <= '0;
    else if (load_i) hold <= cnt;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_CH; i++)
      if (rd_addr_i == ADR_W'(i)) rd_data_o = hold[i];
    if (rd_addr_i == ADR_W'(DIN_ADDR)) rd_data_o = CNT_W'(din_filt);
  end

  a_r5_snap_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> hold == $past(cnt));
  a_r5_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(hold));
  a_r7_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == ADR_W'(DIN_ADDR)) |-> (rd_data_o >> N_DIN) == '0);
endmodule

// File: tb/pulse_count_bank_bench.sv
module pulse_count_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cnt_in = '0;
  logic [9:0]  din = '0;
  logic        load = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] rdata;

  logic [4:0]  n_in = '0;
  logic        n_load = 1'b0;
  logic [2:0]  n_addr = '0;
  logic [11:0] n_rdata;

  int n_chk = 0, n_fail = 0;
  int exp_cnt [5];

  always #4 clk = ~clk;

  pulse_count_bank u_pulse_count_bank (
    .clk_i(clk), .rst_ni(rst_n), .cnt_in_i(cnt_in), .din_i(din),
    .load_i(load), .rd_addr_i(addr), .rd_data_o(rdata)
  );

  pulse_count_bank #(.CNT_W(12)) u_pulse_count_bank_narrow (
    .clk_i(clk), .rst_ni(rst_n), .cnt_in_i(n_in), .din_i(10'h000),
    .load_i(n_load), .rd_addr_i(n_addr), .rd_data_o(n_rdata)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic read_chk(string req, logic [2:0] a, int exp);
    @(negedge clk);
    addr = a;
    #1 check(req, int'(rdata), exp);
  endtask

  task automatic pulse(logic [4:0] mask, int hi, int lo);
    @(negedge clk);
    cnt_in = mask;
    repeat (hi) @(negedge clk);
    cnt_in = '0;
    repeat (lo - 1) @(negedge clk);
    if (hi >= 3)
      for (int c = 0; c < 5; c++) if (mask[c]) exp_cnt[c]++;
  endtask

  task automatic snap();
    @(negedge clk);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) read_chk("R1 reset read", 3'(a), 0);
  endtask

  task automatic t_filter();
    // R2 R8: rise appears at third sampling edge
    @(negedge clk); addr = 3'd5; din = 10'h001;
    @(posedge clk); @(negedge clk); #1 check("R2 rise after 1 edge", int'(rdata), 0);
    @(posedge clk); @(negedge clk); #1 check("R2 rise after 2 edges", int'(rdata), 0);
    @(posedge clk); @(negedge clk); #1 check("R8 rise after 3 edges", int'(rdata), 1);
    din = 10'h000;
    @(posedge clk); @(negedge clk); #1 check("R2 fall after 1 edge", int'(rdata), 1);
    @(posedge clk); @(negedge clk); #1 check("R2 fall after 2 edges", int'(rdata), 1);
    @(posedge clk); @(negedge clk); #1 check("R2 fall after 3 edges", int'(rdata), 0);
    din = 10'h002;
    repeat (2) @(negedge clk);
    din = 10'h000;
    repeat (4) @(negedge clk);
    #1 check("R2 two-clock glitch rejected", int'(rdata), 0);
  endtask

  task automatic t_count();
    for (int k = 0; k < 3; k++) pulse(5'b00001, 3, 3);
    pulse(5'b00100, 4, 5);
    for (int k = 0; k < 2; k++) pulse(5'b10101, 3, 4);
    pulse(5'b00010, 2, 4);
    pulse(5'b11010, 5, 3);
    repeat (3) @(negedge clk);
    snap();
    for (int c = 0; c < 5; c++) read_chk("R3 R6 R9 count readback", 3'(c), exp_cnt[c]);
  endtask

  task automatic t_hold();
    int old [5];
    for (int c = 0; c < 5; c++) old[c] = exp_cnt[c];
    for (int k = 0; k < 2; k++) pulse(5'b11111, 3, 3);
    repeat (3) @(negedge clk);
    for (int c = 0; c < 5; c++) read_chk("R5 hold without strobe", 3'(c), old[c]);
    snap();
    for (int c = 0; c < 5; c++) read_chk("R5 coherent snapshot", 3'(c), exp_cnt[c]);
  endtask

  task automatic t_map();
    @(negedge clk); din = 10'h3FF;
    repeat (4) @(negedge clk);
    read_chk("R7 discrete word zero-extended", 3'd5, 16'h03FF);
    read_chk("R7 address 6 zero", 3'd6, 0);
    read_chk("R7 address 7 zero", 3'd7, 0);
    @(negedge clk); din = 10'h155;
    repeat (4) @(negedge clk);
    read_chk("R8 discrete pattern", 3'd5, 16'h0155);
  endtask

  task automatic n_pulse();
    @(negedge clk); n_in = 5'b00001;
    repeat (3) @(negedge clk);
    n_in = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic n_snap_chk(string req, int exp);
    repeat (3) @(negedge clk);
    n_load = 1'b1;
    @(negedge clk); n_load = 1'b0; n_addr = 3'd0;
    @(negedge clk);
    #1 check(req, int'(n_rdata), exp);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 4095; k++) n_pulse();
    n_snap_chk("R4 all-ones before wrap", 12'hFFF);
    n_pulse();
    n_snap_chk("R4 wrap to zero", 0);
    n_pulse();
    n_snap_chk("R4 count after wrap", 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5; c++) exp_cnt[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_filter();
    t_count();
    t_hold();
    t_map();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule